// File: doc/BRIEF.md
# Switched Input-Device Register Window

This block gives a CPU a 16-byte register window onto the state of its attached input devices. Byte 0 of the window holds a selector. The CPU writes this byte to choose what the other fifteen bytes show: one page of the keyboard key bitmap, the report of one physical gamepad, or a merged gamepad view. The merged view is the bitwise OR of every gamepad that is marked connected. A single-player program can therefore poll one fixed selection and never needs to know which pad is in use.

A host-side write port fills the backing stores. This port belongs to the agent that parses USB reports, and that parsing is outside this block. The stores are a 32-byte key bitmap with one bit per keycode, a keyboard status byte, four 10-byte gamepad reports, and a connected flag for each pad. CPU reads are registered. Each read samples the next state of the stores, so a host write that lands in the same cycle as a CPU read of that byte is already visible in the returned data.

Top module: `hid_window`

## Requirements
- R1: While `rst` is high, the selector, every stored byte, every connected flag and `cpu_rdata` are cleared to zero.
- R2: A CPU write to offset 0 loads `cpu_wdata` into the selector. CPU writes to offsets 1..15 change neither the selector nor any data that can be read back.
- R3: When `cpu_re` is high at a clock edge, `cpu_rdata` shows the byte at `cpu_addr` after that edge. When `cpu_re` is low, `cpu_rdata` holds its value.
- R4: A read at offset 0 returns the keyboard status byte when the selector is 0x01. For every other selector value it returns the selector.
- R5: When the selector low nibble is 1 (keyboard) and the high nibble is 0 or 1 (the page), offset k (1..15) returns bitmap byte 16*page + k.
- R6: When the low nibble is 2 (gamepad) and the high nibble n is 1..4, offset k (1..10) returns byte k-1 of physical pad n. Report bytes are numbered 0..9 and hold, in this order: flags, stick directions, buttons A, buttons B, LX, LY, RX, RY, left trigger, right trigger. Offsets 11..15 read zero for every gamepad selection.
- R7: A physical pad whose connected flag is clear reads zero in offsets 1..15, whatever its stored report holds.
- R8: Gamepad index 0 returns, for each report byte, the bitwise OR of that byte over all pads whose connected flag is set. It returns zero when no pad is connected.
- R9: For any other selection (device type other than 1 or 2, keyboard page above 1, or pad index above 4), offsets 1..15 read zero.
- R10: Host address map (7-bit `host_addr`): 0x00..0x1F write bitmap bytes 0..31; 0x20 writes the status byte; 0x21 writes the connected flags from `host_wdata` bits 3:0, where bit i belongs to pad i+1; 0x40 + 16*(n-1) + b writes byte b (0..9) of pad n. Any other address has no effect.
- R11: When a host write and a CPU read hit the same visible byte in the same cycle, the read returns the newly written host value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 4 | Window offset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_re | input | 1 | CPU read strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Registered CPU read data |
| host_we | input | 1 | Host store write strobe |
| host_addr | input | 7 | Host store address |
| host_wdata | input | 8 | Host store write data |

## Verification
A corrupted selector register shows on the very next offset-0 read, and also as wrong data in every byte that follows, because the selector drives the whole mux. A stale or miswired connected flag shows in two places: the direct read of that pad, which should be zero or the report, and every byte of the merged view. Both appear one cycle after the read strobe. A store byte that was written to the wrong place appears only when its page or pad is selected and the matching offset is read. For that reason the bench sweeps every offset under every selection class.

// File: rtl/hid_pkg.sv
package hid_pkg;
    localparam int WIN_BYTES  = 16;
    localparam int KB_BYTES   = 32;
    localparam int KB_PAGE    = 16;
    localparam int NUM_PADS   = 4;
    localparam int PAD_BYTES  = 10;
    localparam int HOST_AW    = 7;
    localparam int WIN_AW     = $clog2(WIN_BYTES);
    localparam int KB_AW      = $clog2(KB_BYTES);

    localparam logic [3:0] DEV_KBD = 4'd1;
    localparam logic [3:0] DEV_PAD = 4'd2;

    localparam logic [HOST_AW-1:0] HA_KB_STATUS = 7'h20;
    localparam logic [HOST_AW-1:0] HA_PAD_CONN  = 7'h21;

    typedef struct packed {
        logic [3:0] idx;
        logic [3:0] dev;
    } sel_t;

    typedef enum logic [1:0] {
        VIEW_NONE = 2'd0,
        VIEW_KBD  = 2'd1,
        VIEW_PAD  = 2'd2
    } view_e;

    typedef struct packed {
        view_e      kind;
        logic [3:0] idx;
    } view_t;

    function automatic view_t decode_sel(sel_t s);
        view_t v;
        v.idx  = s.idx;
        v.kind = VIEW_NONE;
        if (s.dev == DEV_KBD && s.idx <= 4'd1)
            v.kind = VIEW_KBD;
        else if (s.dev == DEV_PAD && s.idx <= 4'(NUM_PADS))
            v.kind = VIEW_PAD;
        return v;
    endfunction
endpackage

// File: rtl/hid_kbd_store.sv
module hid_kbd_store
    import hid_pkg::*;
#(
    parameter int NB = KB_BYTES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 host_we,
    input  logic [HOST_AW-1:0]   host_addr,
    input  logic [7:0]           host_wdata,
    output logic [NB-1:0][7:0]   kb_d,
    output logic [7:0]           status_d
);
    localparam int IW = $clog2(NB);

    logic [NB-1:0][7:0] kb_q;
    logic [7:0]         status_q;

    always_comb begin
        kb_d     = kb_q;
        status_d = status_q;
        if (host_we) begin
            if (host_addr < HOST_AW'(NB))
                kb_d[host_addr[IW-1:0]] = host_wdata;
            else if (host_addr == HA_KB_STATUS)
                status_d = host_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kb_q     <= '0;
            status_q <= '0;
        end else begin
            kb_q     <= kb_d;
            status_q <= status_d;
        end
    end
endmodule

// File: rtl/hid_pad_store.sv
module hid_pad_store
    import hid_pkg::*;
#(
    parameter int NP = NUM_PADS,
    parameter int PB = PAD_BYTES
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          host_we,
    input  logic [HOST_AW-1:0]            host_addr,
    input  logic [7:0]                    host_wdata,
    output logic [NP-1:0][PB-1:0][7:0]    pad_d,
    output logic [NP-1:0]                 conn_d
);
    logic [NP-1:0][PB-1:0][7:0] pad_q;
    logic [NP-1:0]              conn_q;

    logic       in_pad;
    logic [1:0] wr_pad;
    logic [3:0] wr_byte;

    assign in_pad  = host_we && host_addr[6];
    assign wr_pad  = host_addr[5:4];
    assign wr_byte = host_addr[3:0];

    always_comb begin
        pad_d = pad_q;
        for (int p = 0; p < NP; p++) begin
            if (in_pad && wr_pad == 2'(p) && wr_byte < 4'(PB))
                pad_d[p][wr_byte] = host_wdata;
        end
    end

    always_comb begin
        conn_d = conn_q;
        if (host_we && host_addr == HA_PAD_CONN)
            conn_d = host_wdata[NP-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pad_q  <= '0;
            conn_q <= '0;
        end else begin
            pad_q  <= pad_d;
            conn_q <= conn_d;
        end
    end
endmodule

// File: rtl/hid_pad_merge.sv
module hid_pad_merge
    import hid_pkg::*;
#(
    parameter int NP = NUM_PADS,
    parameter int PB = PAD_BYTES
) (
    input  logic [NP-1:0][PB-1:0][7:0] pads,
    input  logic [NP-1:0]              conn,
    output logic [PB-1:0][7:0]         merged
);
    always_comb begin
        merged = '0;
        for (int p = 0; p < NP; p++) begin
            if (conn[p])
                merged = merged | pads[p];
        end
    end
endmodule

// File: rtl/hid_window.sv
module hid_window
    import hid_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [WIN_AW-1:0]   cpu_addr,
    input  logic                cpu_we,
    input  logic                cpu_re,
    input  logic [7:0]          cpu_wdata,
    output logic [7:0]          cpu_rdata,
    input  logic                host_we,
    input  logic [HOST_AW-1:0]  host_addr,
    input  logic [7:0]          host_wdata
);
    logic [KB_BYTES-1:0][7:0]                  kb_d;
    logic [7:0]                                status_d;
    logic [NUM_PADS-1:0][PAD_BYTES-1:0][7:0]   pad_d;
    logic [NUM_PADS-1:0]                       conn_d;
    logic [PAD_BYTES-1:0][7:0]                 merged;

    sel_t       sel_q;
    view_t      view;
    logic [7:0] rd_byte;
    logic [3:0] pad_m1;
    logic [3:0] rep_byte;

    hid_kbd_store #(.NB(KB_BYTES)) kbd_i (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .kb_d(kb_d), .status_d(status_d)
    );

    hid_pad_store #(.NP(NUM_PADS), .PB(PAD_BYTES)) pads_i (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .pad_d(pad_d), .conn_d(conn_d)
    );

    hid_pad_merge #(.NP(NUM_PADS), .PB(PAD_BYTES)) merge_i (
        .pads(pad_d), .conn(conn_d), .merged(merged)
    );

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= '0;
        else if (cpu_we && cpu_addr == '0)
            sel_q <= sel_t'(cpu_wdata);
    end

    assign view     = decode_sel(sel_q);
    assign pad_m1   = view.idx - 4'd1;
    assign rep_byte = cpu_addr - 4'd1;

    always_comb begin
        rd_byte = '0;
        if (cpu_addr == '0) begin
            if (view.kind == VIEW_KBD && view.idx == 4'd0)
                rd_byte = status_d;
            else
                rd_byte = sel_q;
        end else begin
            unique case (view.kind)
                VIEW_KBD: rd_byte = kb_d[{view.idx[0], cpu_addr}];
                VIEW_PAD: begin
                    if (cpu_addr <= 4'(PAD_BYTES)) begin
                        if (view.idx == 4'd0)
                            rd_byte = merged[rep_byte];
                        else if (conn_d[pad_m1[1:0]])
                            rd_byte = pad_d[pad_m1[1:0]][rep_byte];
                    end
                end
                default: rd_byte = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cpu_rdata <= '0;
        else if (cpu_re)
            cpu_rdata <= rd_byte;
    end
endmodule

// File: rtl/hid_window_chk.sv
module hid_window_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] cpu_addr,
    input logic       cpu_we,
    input logic       cpu_re,
    input logic [7:0] cpu_wdata,
    input logic [7:0] cpu_rdata,
    input logic [7:0] sel_q
);
    logic sel_valid;
    logic sel_is_pad;

    assign sel_is_pad = (sel_q[3:0] == 4'd2) && (sel_q[7:4] <= 4'd4);
    assign sel_valid  = sel_is_pad || ((sel_q[3:0] == 4'd1) && (sel_q[7:4] <= 4'd1));

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (cpu_rdata == 8'd0 && sel_q == 8'd0));

    a_r2_sel_load: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_addr == 4'd0) |=> sel_q == $past(cpu_wdata));

    a_r2_data_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_addr != 4'd0) |=> $stable(sel_q));

    a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !cpu_re |=> $stable(cpu_rdata));

    a_r4_sel_echo: assert property (@(posedge clk) disable iff (rst)
        (cpu_re && !cpu_we && cpu_addr == 4'd0 && sel_q != 8'h01) |=> cpu_rdata == $past(sel_q));

    a_r6_tail_zero: assert property (@(posedge clk) disable iff (rst)
        (cpu_re && sel_is_pad && cpu_addr > 4'd10) |=> cpu_rdata == 8'd0);

    a_r9_invalid_zero: assert property (@(posedge clk) disable iff (rst)
        (cpu_re && !sel_valid && cpu_addr != 4'd0) |=> cpu_rdata == 8'd0);
endmodule

bind hid_window hid_window_chk chk_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_re(cpu_re),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .sel_q(sel_q)
);

// File: tb/hid_window_tb.sv
`timescale 1ns/1ps
module hid_window_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] cpu_addr = '0;
    logic       cpu_we = 1'b0;
    logic       cpu_re = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       host_we = 1'b0;
    logic [6:0] host_addr = '0;
    logic [7:0] host_wdata = '0;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0] m_kb [32];
    logic [7:0] m_status;
    logic [7:0] m_pad [4][10];
    logic [3:0] m_conn;

    always #2.5 clk = ~clk;

    hid_window dut_i (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_re(cpu_re),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata)
    );

    function automatic void model_host(input logic [6:0] a, input logic [7:0] d);
        if (a < 7'd32) m_kb[a[4:0]] = d;
        else if (a == 7'h20) m_status = d;
        else if (a == 7'h21) m_conn = d[3:0];
        else if (a[6] && a[3:0] < 4'd10) m_pad[a[5:4]][a[3:0]] = d;
    endfunction

    function automatic logic [7:0] expect_rd(input logic [7:0] sel, input int off);
        int dev = sel[3:0];
        int idx = sel[7:4];
        logic [7:0] acc = 8'd0;
        if (off == 0) return (sel == 8'h01) ? m_status : sel;
        if (dev == 1 && idx <= 1) return m_kb[idx*16 + off];
        if (dev == 2 && idx <= 4) begin
            if (off > 10) return 8'd0;
            if (idx == 0) begin
                for (int p = 0; p < 4; p++) if (m_conn[p]) acc |= m_pad[p][off-1];
                return acc;
            end
            return m_conn[idx-1] ? m_pad[idx-1][off-1] : 8'd0;
        end
        return 8'd0;
    endfunction

    function automatic string tag_of(input logic [7:0] sel, input int off);
        int dev = sel[3:0];
        int idx = sel[7:4];
        if (off == 0) return "R4";
        if (dev == 1 && idx <= 1) return "R5/R10";
        if (dev == 2 && idx == 0) return (off > 10) ? "R6" : "R8/R10";
        if (dev == 2 && idx <= 4) begin
            if (off > 10) return "R6";
            return m_conn[idx-1] ? "R6/R10" : "R7";
        end
        return "R9";
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
        model_host(a, d);
    endtask

    task automatic cpu_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic cpu_rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_re = 1'b1; cpu_addr = a;
        @(negedge clk);
        cpu_re = 1'b0;
        d = cpu_rdata;
    endtask

    task automatic sweep(input logic [7:0] sel);
        logic [7:0] v;
        cpu_wr(4'd0, sel);
        for (int off = 0; off < 16; off++) begin
            cpu_rd(4'(off), v);
            check(v, expect_rd(sel, off), $sformatf("%s sel=0x%02h off=%0d", tag_of(sel, off), sel, off));
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] sels [12];
        for (int i = 0; i < 32; i++) m_kb[i] = 8'd0;
        for (int p = 0; p < 4; p++) for (int j = 0; j < 10; j++) m_pad[p][j] = 8'd0;
        m_status = 8'd0;
        m_conn = 4'd0;

        repeat (3) @(negedge clk);
        check(cpu_rdata, 8'd0, "R1 rdata after reset");
        rst = 1'b0;

        // R1: cleared selector and stores
        cpu_rd(4'd0, v);
        check(v, 8'd0, "R1 selector cleared");
        cpu_wr(4'd0, 8'h11);
        cpu_rd(4'd5, v);
        check(v, 8'd0, "R1 keyboard store cleared");
        cpu_wr(4'd0, 8'h01);
        cpu_rd(4'd0, v);
        check(v, 8'd0, "R1 status cleared");

        // R10: fill stores through host port
        for (int i = 0; i < 32; i++) host_wr(7'(i), 8'(i * 29 + 7));
        host_wr(7'h20, 8'h0B);
        for (int p = 0; p < 4; p++)
            for (int j = 0; j < 10; j++)
                host_wr(7'h40 + 7'(p * 16 + j), 8'(p * 53 + j * 17 + 1));
        host_wr(7'h4C, 8'hFF);
        host_wr(7'h21, 8'hFB);

        sels = '{8'h01, 8'h11, 8'h21, 8'h02, 8'h12, 8'h22, 8'h32, 8'h42,
                 8'h52, 8'h03, 8'h00, 8'hF1};
        foreach (sels[k]) sweep(sels[k]);

        // R7/R8: new connection pattern
        host_wr(7'h21, 8'h05);
        sweep(8'h02);
        sweep(8'h22);
        sweep(8'h32);
        host_wr(7'h21, 8'h00);
        sweep(8'h02);
        host_wr(7'h21, 8'h05);

        // R2: data offsets ignore CPU writes
        cpu_wr(4'd0, 8'h12);
        cpu_wr(4'd7, 8'h55);
        cpu_rd(4'd0, v);
        check(v, 8'h12, "R2 selector unchanged");
        cpu_rd(4'd7, v);
        check(v, expect_rd(8'h12, 7), "R2 data unchanged");

        // R3: hold without read strobe
        cpu_rd(4'd3, v);
        @(negedge clk);
        cpu_addr = 4'd9;
        @(negedge clk);
        @(negedge clk);
        check(cpu_rdata, v, "R3 hold while idle");
        check(v, expect_rd(8'h12, 3), "R3 read value");

        // R11: same-cycle host write and CPU read
        @(negedge clk);
        host_we = 1'b1; host_addr = 7'h43; host_wdata = 8'hC3;
        cpu_re = 1'b1; cpu_addr = 4'd4;
        @(negedge clk);
        host_we = 1'b0; cpu_re = 1'b0;
        model_host(7'h43, 8'hC3);
        check(cpu_rdata, 8'hC3, "R11 physical pad bypass");

        cpu_wr(4'd0, 8'h02);
        @(negedge clk);
        host_we = 1'b1; host_addr = 7'h60; host_wdata = 8'h81;
        cpu_re = 1'b1; cpu_addr = 4'd1;
        @(negedge clk);
        host_we = 1'b0; cpu_re = 1'b0;
        model_host(7'h60, 8'h81);
        check(cpu_rdata, expect_rd(8'h02, 1), "R11 merged bypass");

        cpu_wr(4'd0, 8'h01);
        @(negedge clk);
        host_we = 1'b1; host_addr = 7'h20; host_wdata = 8'h05;
        cpu_re = 1'b1; cpu_addr = 4'd0;
        @(negedge clk);
        host_we = 1'b0; cpu_re = 1'b0;
        model_host(7'h20, 8'h05);
        check(cpu_rdata, 8'h05, "R11 status bypass");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule